// File: doc/BRIEF.md
# Power-Loss Sector Write Guard

This controller sits between a host byte stream that fills a sector buffer and the engine that programs that buffer into flash. It counts the bytes that the host hands over one by one. When a full sector has arrived, it sends a single commit pulse to the programming engine and reports busy until the engine reports completion. Sector size and the hold-up window are parameters; the default sector is 512 bytes.

A raw supply-valid level enters through a short synchroniser. Once the synchronised level shows a failure, the guard refuses host bytes at once. A sector that is only partly received is discarded and its byte counter is cleared. A sector that was fully received (whether its commit is pending or already under way) is allowed to finish on hold-up power. A counter measures how many cycles the hold-up window has lasted. If the engine does not finish inside `HOLDUP_CYCLES`, a sticky flag marks the write as not guaranteed. Either way, the guard then parks in a terminal state where nothing can reach the flash until reset.

`HOLDUP_CYCLES` is the guaranteed hold-up time in clock cycles, at least 2. For example, 10 ms at 200 MHz is 2,000,000. The flash array, the hold-up supply and the voltage comparator lie outside the block.

Top module: `pwrloss_sector_guard`

## Requirements
- R1: `supplyOkRaw` passes through `SYNC_STAGES` (default 2) flops before use. After reset is released with the supply valid, `hostReady` first goes high after three rising edges.
- R2: A byte is accepted on an edge where `hostValid` and `hostReady` are both 1. `byteCount` shows the number of bytes accepted in the current sector. `commitStrobe` is high for exactly one cycle, the cycle after the edge that accepted byte `SECTOR_BYTES`. In that cycle `byteCount` is 0.
- R3: `rdyBsy` is 1 only while the guard is idle or receiving. It is 0 from the commit cycle through the cycle in which `progDone` is high. It returns to 1 in the following cycle when the supply is valid.
- R4: While the synchronised supply is invalid, `hostReady` is 0 and no byte is accepted. If the raw supply drops before edge E1, bytes offered at E1 and E2 are still taken and a byte offered at E3 is refused.
- R5: A sector that is partly received when the failure is seen produces no commit. `byteCount` returns to 0 and `parked` goes to 1.
- R6: A sector that was completed before the failure is seen gets exactly one commit and is allowed to finish. The guard parks when `progDone` arrives.
- R7: `holdCount` counts cycles from the first cycle the failure is seen during a pending or running program, up to and including the cycle that ends the hold-up. It stops at `HOLDUP_CYCLES`.
- R8: If `progDone` has not come by the cycle where `holdCount` equals `HOLDUP_CYCLES-1`, the guard parks anyway and sets `holdupExpired`. At that point `holdCount` equals `HOLDUP_CYCLES`. A `progDone` that arrives in that same cycle counts as a clean finish.
- R9: While `parked` is 1, `commitStrobe`, `hostReady` and `rdyBsy` stay 0 and `progDone` has no effect. `parked` clears only on reset.
- R10: After reset, `hostReady` stays 0 while the synchronised supply is invalid, with `parked` at 0. It rises once the supply becomes valid.
- R11: If the last byte of a sector is offered in the first cycle the failure is seen, that byte is refused and the sector is dropped as in R5.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| supplyOkRaw | input | 1 | Unsynchronised supply-valid level from the comparator |
| hostValid | input | 1 | Host offers a sector byte |
| hostReady | output | 1 | Guard takes the offered byte this cycle |
| progDone | input | 1 | One-cycle completion pulse from the programming engine |
| commitStrobe | output | 1 | One-cycle request to program the buffered sector |
| rdyBsy | output | 1 | 1 = ready, 0 = busy |
| parked | output | 1 | Terminal power-down state reached |
| holdupExpired | output | 1 | Hold-up window ran out before the program finished |
| byteCount | output | $clog2(SECTOR_BYTES) | Bytes received in the current sector |
| holdCount | output | $clog2(HOLDUP_CYCLES+1) | Cycles of hold-up operation so far |

## Verification
Two collisions matter most. The first is a sector's last byte being offered in the first cycle the synchronised supply is low. The second is the engine's completion pulse landing in the same cycle as the last allowed hold-up cycle. The bench provokes the first by sweeping the raw drop point across every byte position of a small sector, and the second by sweeping the stub engine's latency across the hold-up limit. For every point it computes the accepted byte count, the number of commits, the final hold counter and the expiry flag from the synchroniser depth and the window length.

// File: rtl/psg_pkg.sv
package psg_pkg;

  typedef enum logic [2:0] {
    ST_WAITPWR = 3'd0,
    ST_RECV    = 3'd1,
    ST_COMMIT  = 3'd2,
    ST_PROG    = 3'd3,
    ST_HOLD    = 3'd4,
    ST_DOWN    = 3'd5
  } guardState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic cntInc;
    logic cntClear;
    logic holdRun;
    logic markExpired;
  } guardStb_t;

endpackage

// File: rtl/psg_sync.sv
module psg_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] pipe;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) pipe <= '0;
        else       pipe <= din;
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) pipe <= '0;
        else       pipe <= {pipe[STAGES-2:0], din};
      end
    end
  endgenerate

  // reset value means "supply not yet trusted"
  assign dout = pipe[STAGES-1];
endmodule

// File: rtl/psg_datapath.sv
module psg_datapath
  import psg_pkg::*;
#(
  parameter int SECTOR_BYTES  = 512,
  parameter int HOLDUP_CYCLES = 2000000,
  localparam int CNT_W  = $clog2(SECTOR_BYTES),
  localparam int HOLD_W = $clog2(HOLDUP_CYCLES + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  guardStb_t         stb,
  output logic              atLast,
  output logic              holdHit,
  output logic [CNT_W-1:0]  byteCount,
  output logic [HOLD_W-1:0] holdCount,
  output logic              holdupExpired
);
  logic [CNT_W-1:0]  byteCnt;
  logic [HOLD_W-1:0] holdCnt;
  logic              expiredQ;
  logic              holdFull;

  // sector byte counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            byteCnt <= '0;
    else if (stb.cntClear) byteCnt <= '0;
    else if (stb.cntInc)   byteCnt <= byteCnt + 1'b1;
  end

  // hold-up duration counter, saturating
  assign holdFull = (holdCnt == HOLD_W'(HOLDUP_CYCLES));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                      holdCnt <= '0;
    else if (stb.holdRun && !holdFull) holdCnt <= holdCnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               expiredQ <= 1'b0;
    else if (stb.markExpired) expiredQ <= 1'b1;
  end

  assign atLast        = (byteCnt == CNT_W'(SECTOR_BYTES - 1));
  assign holdHit       = (holdCnt == HOLD_W'(HOLDUP_CYCLES - 1));
  assign byteCount     = byteCnt;
  assign holdCount     = holdCnt;
  assign holdupExpired = expiredQ;
endmodule

// File: rtl/psg_ctrl.sv
module psg_ctrl
  import psg_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      supOk,
  input  logic      hostValid,
  input  logic      progDone,
  input  logic      atLast,
  input  logic      holdHit,
  output guardStb_t stb,
  output logic      hostReady,
  output logic      rdyBsy,
  output logic      commitStrobe,
  output logic      parked
);
  guardState_t state, nxtState;
  logic        accept;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_WAITPWR;
    else       state <= nxtState;
  end

  assign hostReady = (state == ST_RECV) && supOk;
  assign accept    = hostValid && hostReady;

  always_comb begin
    nxtState = state;
    stb      = '0;
    unique case (state)
      ST_WAITPWR: begin
        if (supOk) nxtState = ST_RECV;
      end
      ST_RECV: begin
        if (!supOk) begin
          // partial sector is abandoned
          nxtState     = ST_DOWN;
          stb.cntClear = 1'b1;
        end else if (accept) begin
          if (atLast) begin
            nxtState     = ST_COMMIT;
            stb.cntClear = 1'b1;
          end else begin
            stb.cntInc = 1'b1;
          end
        end
      end
      ST_COMMIT: begin
        stb.holdRun = !supOk;
        nxtState    = supOk ? ST_PROG : ST_HOLD;
      end
      ST_PROG: begin
        stb.holdRun = !supOk;
        if (progDone)    nxtState = supOk ? ST_RECV : ST_DOWN;
        else if (!supOk) nxtState = ST_HOLD;
      end
      ST_HOLD: begin
        stb.holdRun = 1'b1;
        if (progDone) begin
          nxtState = ST_DOWN;
        end else if (holdHit) begin
          nxtState        = ST_DOWN;
          stb.markExpired = 1'b1;
        end
      end
      ST_DOWN: nxtState = ST_DOWN;
      default: nxtState = ST_DOWN;
    endcase
  end

  assign commitStrobe = (state == ST_COMMIT);
  assign rdyBsy       = (state == ST_RECV);
  assign parked       = (state == ST_DOWN);
endmodule

// File: rtl/pwrloss_sector_guard.sv
module pwrloss_sector_guard
  import psg_pkg::*;
#(
  parameter int SECTOR_BYTES  = 512,
  parameter int HOLDUP_CYCLES = 2000000,
  parameter int SYNC_STAGES   = 2,
  localparam int CNT_W  = $clog2(SECTOR_BYTES),
  localparam int HOLD_W = $clog2(HOLDUP_CYCLES + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              supplyOkRaw,
  input  logic              hostValid,
  output logic              hostReady,
  input  logic              progDone,
  output logic              commitStrobe,
  output logic              rdyBsy,
  output logic              parked,
  output logic              holdupExpired,
  output logic [CNT_W-1:0]  byteCount,
  output logic [HOLD_W-1:0] holdCount
);
  logic      supOk;
  logic      atLast;
  logic      holdHit;
  guardStb_t stb;

  psg_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rstN (rstN),
    .din  (supplyOkRaw),
    .dout (supOk)
  );

  psg_ctrl u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .supOk        (supOk),
    .hostValid    (hostValid),
    .progDone     (progDone),
    .atLast       (atLast),
    .holdHit      (holdHit),
    .stb          (stb),
    .hostReady    (hostReady),
    .rdyBsy       (rdyBsy),
    .commitStrobe (commitStrobe),
    .parked       (parked)
  );

  psg_datapath #(
    .SECTOR_BYTES  (SECTOR_BYTES),
    .HOLDUP_CYCLES (HOLDUP_CYCLES)
  ) u_dp (
    .clk           (clk),
    .rstN          (rstN),
    .stb           (stb),
    .atLast        (atLast),
    .holdHit       (holdHit),
    .byteCount     (byteCount),
    .holdCount     (holdCount),
    .holdupExpired (holdupExpired)
  );
endmodule

// File: rtl/psg_checker.sv
module psg_checker #(
  parameter int SECTOR_BYTES  = 512,
  parameter int HOLDUP_CYCLES = 2000000,
  localparam int CNT_W  = $clog2(SECTOR_BYTES),
  localparam int HOLD_W = $clog2(HOLDUP_CYCLES + 1)
) (
  input logic              clk,
  input logic              rstN,
  input logic              supOk,
  input logic              hostValid,
  input logic              hostReady,
  input logic              commitStrobe,
  input logic              rdyBsy,
  input logic              parked,
  input logic              holdupExpired,
  input logic [CNT_W-1:0]  byteCount,
  input logic [HOLD_W-1:0] holdCount
);
  AST_NO_TAKE_WHEN_LOST: assert property (@(posedge clk) disable iff (!rstN)
    !supOk |-> !hostReady); // R4

  AST_COMMIT_AFTER_FULL: assert property (@(posedge clk) disable iff (!rstN)
    commitStrobe |-> $past(hostValid && hostReady && byteCount == CNT_W'(SECTOR_BYTES - 1))); // R2

  AST_COMMIT_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    commitStrobe |=> !commitStrobe); // R2

  AST_BUSY_ON_COMMIT: assert property (@(posedge clk) disable iff (!rstN)
    commitStrobe |-> !rdyBsy); // R3

  AST_PARK_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    parked |=> parked); // R9

  AST_PARK_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    parked |-> (!commitStrobe && !hostReady && !rdyBsy)); // R9

  AST_EXPIRE_AT_LIMIT: assert property (@(posedge clk) disable iff (!rstN)
    $rose(holdupExpired) |-> (holdCount == HOLD_W'(HOLDUP_CYCLES) && parked)); // R8

  AST_HOLD_SATURATES: assert property (@(posedge clk) disable iff (!rstN)
    holdCount <= HOLD_W'(HOLDUP_CYCLES)); // R7
endmodule

bind pwrloss_sector_guard psg_checker #(
  .SECTOR_BYTES  (SECTOR_BYTES),
  .HOLDUP_CYCLES (HOLDUP_CYCLES)
) u_chk (
  .clk           (clk),
  .rstN          (rstN),
  .supOk         (supOk),
  .hostValid     (hostValid),
  .hostReady     (hostReady),
  .commitStrobe  (commitStrobe),
  .rdyBsy        (rdyBsy),
  .parked        (parked),
  .holdupExpired (holdupExpired),
  .byteCount     (byteCount),
  .holdCount     (holdCount)
);

// File: tb/pwrloss_sector_guard_tb.sv
module pwrloss_sector_guard_tb;
  localparam int SB = 8;
  localparam int HC = 16;
  localparam int CW = $clog2(SB);
  localparam int HW = $clog2(HC + 1);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic supplyOkRaw = 1'b1;
  logic hostValid = 1'b0;
  logic hostReady, progDone, commitStrobe, rdyBsy, parked, holdupExpired;
  logic [CW-1:0] byteCount;
  logic [HW-1:0] holdCount;

  int nChecks = 0;
  int nFails = 0;
  int commits = 0;
  int accepted = 0;
  int stubP = 3;
  int pcnt = 0;
  int cyc = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  pwrloss_sector_guard #(.SECTOR_BYTES(SB), .HOLDUP_CYCLES(HC), .SYNC_STAGES(2)) u_dut (
    .clk(clk), .rstN(rstN), .supplyOkRaw(supplyOkRaw), .hostValid(hostValid),
    .hostReady(hostReady), .progDone(progDone), .commitStrobe(commitStrobe),
    .rdyBsy(rdyBsy), .parked(parked), .holdupExpired(holdupExpired),
    .byteCount(byteCount), .holdCount(holdCount));

  // programming engine stub: done pulse stubP cycles after the commit cycle
  always @(posedge clk) begin
    if (!rstN) pcnt <= 0;
    else if (commitStrobe) pcnt <= stubP;
    else if (pcnt != 0) pcnt <= pcnt - 1;
  end
  assign progDone = (pcnt == 1);

  always @(posedge clk) begin
    if (rstN && commitStrobe) commits <= commits + 1;
    if (rstN && hostValid && hostReady) accepted <= accepted + 1;
  end

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000 && !done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: act=%0d exp=<150000 cycles", cyc);
      summary();
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: act=%0d exp=%0d (t=%0t)", tag, act, exp, $time);
    end
  endtask

  task automatic doReset(input logic rawLevel);
    @(negedge clk);
    rstN = 1'b0;
    hostValid = 1'b0;
    supplyOkRaw = rawLevel;
    repeat (3) @(negedge clk);
    commits = 0;
    accepted = 0;
    rstN = 1'b1;
  endtask

  // R1: hostReady first rises after three edges
  task automatic waitReady();
    check(hostReady == 1'b0, "R1 ready before sync", hostReady, 0);
    @(negedge clk);
    @(negedge clk);
    check(hostReady == 1'b0, "R1 ready after 2 edges", hostReady, 0);
    @(negedge clk);
    check(hostReady == 1'b1, "R1 ready after 3 edges", hostReady, 1);
  endtask

  // sends one full sector; returns at the negedge of the commit cycle
  task automatic sendSector();
    hostValid = 1'b1;
    for (int i = 0; i < SB; i++) begin
      check(byteCount == CW'(i), "R2 byteCount", byteCount, i);
      @(posedge clk);
      @(negedge clk);
    end
    hostValid = 1'b0;
    check(commitStrobe == 1'b1, "R2 commit pulse", commitStrobe, 1);
    check(byteCount == 0, "R2 count cleared on commit", byteCount, 0);
    check(rdyBsy == 1'b0, "R3 busy in commit cycle", rdyBsy, 0);
  endtask

  initial begin
    // reset state
    doReset(1'b1);
    check(rdyBsy == 1'b0 && parked == 1'b0 && commitStrobe == 1'b0, "R10 reset outputs", {rdyBsy, parked, commitStrobe}, 0);
    check(byteCount == 0 && holdCount == 0 && holdupExpired == 1'b0, "R7 reset counters", holdCount, 0);
    waitReady();
    check(rdyBsy == 1'b1, "R3 ready when idle", rdyBsy, 1);

    // normal back-to-back sectors
    stubP = 3;
    for (int s = 0; s < 3; s++) begin
      sendSector();
      for (int j = 1; j <= stubP; j++) begin
        @(negedge clk);
        check(rdyBsy == 1'b0, "R3 busy while programming", rdyBsy, 0);
        check(commitStrobe == 1'b0, "R2 single commit cycle", commitStrobe, 0);
      end
      @(negedge clk);
      check(rdyBsy == 1'b1, "R3 ready after done", rdyBsy, 1);
      check(commits == s + 1, "R2 commit count", commits, s + 1);
    end

    // loss during reception, swept over the drop point
    stubP = 4;
    for (int k = 0; k <= SB + 1; k++) begin
      int expAcc;
      int expCommits;
      doReset(1'b1);
      waitReady();
      hostValid = 1'b1;
      repeat (k) @(negedge clk);
      supplyOkRaw = 1'b0;
      repeat (30) @(negedge clk);
      check(hostReady == 1'b0, "R4 no ready after loss", hostReady, 0);
      hostValid = 1'b0;
      expAcc = (k + 2 < SB) ? k + 2 : SB;
      expCommits = (k + 2 >= SB) ? 1 : 0;
      check(accepted == expAcc, "R4 bytes accepted", accepted, expAcc);
      if (k + 2 == SB - 1)
        check(commits == expCommits, "R11 last byte refused in loss cycle", commits, expCommits);
      else if (expCommits == 0)
        check(commits == 0, "R5 partial sector dropped", commits, 0);
      else
        check(commits == 1, "R6 complete sector committed", commits, 1);
      check(byteCount == 0, "R5 count cleared", byteCount, 0);
      check(parked == 1'b1, "R6 parked after loss", parked, 1);
      check(holdupExpired == 1'b0, "R8 no expiry", holdupExpired, 0);
      check(rdyBsy == 1'b0, "R9 busy while parked", rdyBsy, 0);
    end

    // loss right at commit, engine latency swept across the window
    for (int p = 1; p <= HC + 4; p++) begin
      int expExp;
      int expHold;
      stubP = p;
      doReset(1'b1);
      waitReady();
      sendSector();
      supplyOkRaw = 1'b0;
      repeat (HC + 30) @(negedge clk);
      expExp = (p - 2 >= HC) ? 1 : 0;
      expHold = (p == 1) ? 0 : (expExp != 0 ? HC : p - 1);
      check(commits == 1, "R9 no commit after park", commits, 1);
      check(parked == 1'b1, "R6 parked after hold-up", parked, 1);
      check(int'(holdupExpired) == expExp, "R8 expiry flag", holdupExpired, expExp);
      check(int'(holdCount) == expHold, "R7 hold count", holdCount, expHold);
    end

    // reset clears park; supply bad during reset keeps the guard idle
    doReset(1'b0);
    check(parked == 1'b0, "R9 reset leaves park", parked, 0);
    repeat (10) @(negedge clk);
    check(hostReady == 1'b0 && parked == 1'b0, "R10 waits for supply", hostReady, 0);
    supplyOkRaw = 1'b1;
    repeat (3) @(negedge clk);
    check(hostReady == 1'b1, "R10 ready once supply valid", hostReady, 1);

    done = 1'b1;
    summary();
  end
endmodule